// File: doc/BRIEF.md
# SMBus Master Write Sequencer with Packet Error Code

This block runs the byte order of an SMBus master write transfer. Software first sets up a byte count, an address byte, a flag that enables the packet error code (PEC) and a flag that picks the ending. It then pulses a start request. The block asks a byte-level bus engine for a START and sends the address byte. It then asks the host for each data byte with a one-cycle request pulse and takes the byte on a write strobe. Every byte waits for the engine's completion pulse and acknowledge bit before the next one goes out.

When PEC is on, the PEC byte counts as the last byte of the programmed count. The block computes it as a CRC-8 over the address and data bytes and sends it without asking the host. After the last byte the block does one of two things. With the ending flag set, it asks for a STOP and goes idle. With the flag clear, it sets a completion flag and holds the bus, so that the next start request becomes a repeated START.

A negative acknowledge on any byte ends the transfer at once with a STOP request and a sticky flag.

Top module: `smbus_pec_tx_seq`

## Requirements
- R1: After reset the block is idle. `busy`, `bus_hold`, `xfer_done`, `nack_flag`, `tx_req`, `bus_start`, `bus_byte_valid` and `bus_stop` are all 0.
- R2: `start_req` is accepted only while the block is idle or holding. The settings are captured at acceptance: `addr_byte`, `byte_count`, `pec_en` and `auto_end`. A start request or a settings change while `busy` is 1 has no effect on the running transfer.
- R3: An accepted start produces one cycle in which `bus_start` and `bus_byte_valid` are both 1. In that cycle `bus_byte` carries the address byte.
- R4: With `pec_en`=1 and a count N≥1, the host sees exactly N-1 `tx_req` pulses. The bus receives the address, N-1 host bytes in order, and then the PEC byte.
- R5: With `pec_en`=0 and a count N, the host sees exactly N `tx_req` pulses, and the bus receives the address and N host bytes. No extra byte is sent.
- R6: The PEC is a CRC-8 with polynomial 0x07 (x^8+x^2+x+1) and initial value 0x00. It is computed MSB first over the address byte and every host data byte of the frame.
- R7: With `auto_end`=1, the acknowledged last byte is followed by a one-cycle `bus_stop`. `xfer_done` then reads 1 and the block goes back to idle.
- R8: With `auto_end`=0, no `bus_stop` follows the last byte. The block sets `xfer_done` and holds `bus_hold`=1. A start request accepted from the hold state issues a repeated START.
- R9: The CRC restarts from 0x00 at every accepted start, including a repeated START. The PEC therefore covers only the current frame.
- R10: A byte that completes with `bus_ack`=0 aborts the transfer. `nack_flag` is set, one `bus_stop` pulse follows, no further byte or request is issued, and `xfer_done` stays 0.
- R11: With `pec_en`=1 and a count of 1, the PEC byte follows the address with no `tx_req`. A count of 0 sends only the address.
- R12: Only one byte is in flight at a time. `bus_byte_valid` is not raised again until `bus_byte_done` has answered the previous byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_req | input | 1 | Start pulse; accepted when idle or holding |
| addr_byte | input | 8 | Address byte, including the direction bit |
| byte_count | input | CNT_W | Number of bytes after the address, with the PEC included |
| pec_en | input | 1 | Append the computed PEC as the last counted byte |
| auto_end | input | 1 | 1: STOP after the last byte; 0: hold for a repeated START |
| tx_req | output | 1 | One-cycle request to the host for the next data byte |
| wr_strobe | input | 1 | Host write strobe for `wr_data` |
| wr_data | input | 8 | Host data byte |
| bus_start | output | 1 | Request a START or repeated START to the engine |
| bus_byte_valid | output | 1 | One-cycle pulse: `bus_byte` is to be sent |
| bus_byte | output | 8 | Byte handed to the engine |
| bus_byte_done | input | 1 | Engine has finished the current byte |
| bus_ack | input | 1 | Acknowledge seen on that byte (1 = ACK) |
| bus_stop | output | 1 | Request a STOP |
| busy | output | 1 | Transfer in progress |
| bus_hold | output | 1 | Bus held after a transfer that did not end with a STOP |
| xfer_done | output | 1 | Last transfer completed; cleared at the next accepted start |
| nack_flag | output | 1 | Last transfer ended on a NACK; cleared at the next accepted start |

## Verification
The bench goes after the off-by-one edge of the PEC count. It checks that N-1 requests arrive with PEC on and N with it off, and a count of 1 with PEC must produce no host request at all. A design that miscounts either asks the host for a byte it then overwrites or sends an extra byte.

A repeated START from the hold state is checked against a PEC over the second frame alone; a CRC that is not cleared would give a wrong code there. A start pulse with altered settings in the middle of a transfer must leave the frame untouched. A NACK in mid-frame must stop all further requests, where a broken abort would keep asking the host for bytes.

// File: rtl/smbus_pec_pkg.sv
// Shared state encoding and the CRC step used by the PEC sequencer.
// Assumes 8-bit bytes shifted MSB first.
package smbus_pec_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WAIT,
        ST_ASK,
        ST_REQ,
        ST_DATA,
        ST_PEC,
        ST_STOP,
        ST_HOLD
    } seq_state_t;

    // One byte of CRC-8, MSB first, with the given polynomial.
    function automatic logic [7:0] crc8_step(input logic [7:0] crc_in,
                                             input logic [7:0] din,
                                             input logic [7:0] poly);
        logic [7:0] c;
        logic       fb;
        c = crc_in;
        for (int i = 7; i >= 0; i--) begin
            fb = c[7] ^ din[i];
            c  = {c[6:0], 1'b0};
            if (fb) c = c ^ poly;
        end
        return c;
    endfunction

endpackage

// File: rtl/pec_crc_acc.sv
// CRC-8 accumulator for the packet error code.
// Clear wins over update; one byte is folded in per enabled cycle.
module pec_crc_acc #(
    parameter logic [7:0] POLY = 8'h07,
    parameter logic [7:0] INIT = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  logic [7:0] din,
    output logic [7:0] crc
);
    import smbus_pec_pkg::*;

    // Holds the running CRC of the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n)   crc <= INIT;
        else if (clr) crc <= INIT;
        else if (en)  crc <= crc8_step(crc, din, POLY);
    end
endmodule

// File: rtl/xfer_count.sv
// Remaining-byte counter: loaded at start, decremented per data or PEC byte.
// Assumes dec is never raised when the count is already zero.
module xfer_count #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             is_zero,
    output logic             is_one
);
    logic [CNT_W-1:0] rem;

    // Tracks how many counted bytes are still to be sent.
    always_ff @(posedge clk) begin
        if (!rst_n)     rem <= '0;
        else if (load)  rem <= load_val;
        else if (dec)   rem <= rem - 1'b1;
    end

    // Decodes the two counts the sequencer branches on.
    always_comb begin
        is_zero = (rem == '0);
        is_one  = (rem == CNT_W'(1));
    end
endmodule

// File: rtl/seq_ctrl.sv
// Transfer state machine: address, host requests, PEC insertion and ending.
// Assumes the engine answers each launched byte with one bus_byte_done pulse.
module seq_ctrl (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_req,
    input  logic                      pec_en,
    input  logic                      auto_end,
    input  logic                      is_zero,
    input  logic                      is_one,
    input  logic                      wr_strobe,
    input  logic                      byte_done,
    input  logic                      ack,
    output smbus_pec_pkg::seq_state_t st,
    output logic                      accept,
    output logic                      done_flag,
    output logic                      nack_flag
);
    import smbus_pec_pkg::*;

    seq_state_t nxt;
    logic       pec_q;
    logic       ae_q;
    logic       fin;

    // A start counts only while idle or holding.
    always_comb begin
        accept = start_req && (st == ST_IDLE || st == ST_HOLD);
    end

    // Chooses the next step of the transfer.
    always_comb begin
        nxt = st;
        fin = 1'b0;
        unique case (st)
            ST_IDLE, ST_HOLD: if (accept) nxt = ST_ADDR;
            ST_ADDR, ST_DATA, ST_PEC: nxt = ST_WAIT;
            ST_WAIT: if (byte_done) begin
                if (!ack)                 nxt = ST_STOP;
                else if (is_zero) begin
                    fin = 1'b1;
                    nxt = ae_q ? ST_STOP : ST_HOLD;
                end
                else if (pec_q && is_one) nxt = ST_PEC;
                else                      nxt = ST_ASK;
            end
            ST_ASK:  nxt = ST_REQ;
            ST_REQ:  if (wr_strobe) nxt = ST_DATA;
            ST_STOP: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // Captures the mode flags at the accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pec_q <= 1'b0;
            ae_q  <= 1'b0;
        end else if (accept) begin
            pec_q <= pec_en;
            ae_q  <= auto_end;
        end
    end

    // Sticky result flags, cleared by the next accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_flag <= 1'b0;
            nack_flag <= 1'b0;
        end else if (accept) begin
            done_flag <= 1'b0;
            nack_flag <= 1'b0;
        end else begin
            if (fin)                                      done_flag <= 1'b1;
            if (st == ST_WAIT && byte_done && !ack)       nack_flag <= 1'b1;
        end
    end
endmodule

// File: rtl/smbus_pec_tx_seq.sv
// Top of the SMBus master write sequencer with hardware PEC insertion.
// Assumes a byte-level engine that turns bus_start/bus_byte/bus_stop into
// bus conditions and reports each byte with bus_byte_done and bus_ack.
module smbus_pec_tx_seq #(
    parameter int         CNT_W = 8,
    parameter logic [7:0] POLY  = 8'h07
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic [7:0]       addr_byte,
    input  logic [CNT_W-1:0] byte_count,
    input  logic             pec_en,
    input  logic             auto_end,
    output logic             tx_req,
    input  logic             wr_strobe,
    input  logic [7:0]       wr_data,
    output logic             bus_start,
    output logic             bus_byte_valid,
    output logic [7:0]       bus_byte,
    input  logic             bus_byte_done,
    input  logic             bus_ack,
    output logic             bus_stop,
    output logic             busy,
    output logic             bus_hold,
    output logic             xfer_done,
    output logic             nack_flag
);
    import smbus_pec_pkg::*;

    seq_state_t st;
    logic       accept;
    logic       is_zero;
    logic       is_one;
    logic [7:0] addr_q;
    logic [7:0] data_q;
    logic [7:0] crc;
    logic       crc_en;
    logic [7:0] crc_din;

    seq_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .pec_en    (pec_en),
        .auto_end  (auto_end),
        .is_zero   (is_zero),
        .is_one    (is_one),
        .wr_strobe (wr_strobe),
        .byte_done (bus_byte_done),
        .ack       (bus_ack),
        .st        (st),
        .accept    (accept),
        .done_flag (xfer_done),
        .nack_flag (nack_flag)
    );

    xfer_count #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (byte_count),
        .dec      (st == ST_DATA || st == ST_PEC),
        .is_zero  (is_zero),
        .is_one   (is_one)
    );

    pec_crc_acc #(.POLY(POLY), .INIT(8'h00)) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .en    (crc_en),
        .din   (crc_din),
        .crc   (crc)
    );

    // Latches the address at start and each host byte on its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else begin
            if (accept)                   addr_q <= addr_byte;
            if (st == ST_REQ && wr_strobe) data_q <= wr_data;
        end
    end

    // Feeds the CRC with address and host bytes, never the PEC itself.
    always_comb begin
        crc_en  = (st == ST_ADDR) || (st == ST_DATA);
        crc_din = (st == ST_ADDR) ? addr_q : data_q;
    end

    // Drives the engine and host strobes from the current state.
    always_comb begin
        bus_start      = (st == ST_ADDR);
        bus_byte_valid = (st == ST_ADDR) || (st == ST_DATA) || (st == ST_PEC);
        bus_stop       = (st == ST_STOP);
        tx_req         = (st == ST_ASK);
        busy           = (st != ST_IDLE) && (st != ST_HOLD);
        bus_hold       = (st == ST_HOLD);
        unique case (st)
            ST_ADDR: bus_byte = addr_q;
            ST_PEC:  bus_byte = crc;
            default: bus_byte = data_q;
        endcase
    end
endmodule

// File: rtl/smbus_pec_tx_seq_chk.sv
// Protocol checker for the sequencer, bound to every instance of the top.
// Observes only ports; keeps its own record of the byte in flight.
module smbus_pec_tx_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_start,
    input logic bus_byte_valid,
    input logic bus_byte_done,
    input logic bus_ack,
    input logic bus_stop,
    input logic busy,
    input logic bus_hold,
    input logic xfer_done,
    input logic nack_flag,
    input logic tx_req
);
    logic inflight;

    // Marks a byte handed to the engine and not yet answered.
    always_ff @(posedge clk) begin
        if (!rst_n)              inflight <= 1'b0;
        else if (bus_byte_valid) inflight <= 1'b1;
        else if (bus_byte_done)  inflight <= 1'b0;
    end

    assert_single_byte_R12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_byte_valid |-> !inflight);

    assert_start_carries_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |-> bus_byte_valid);

    assert_flags_cleared_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |-> (!xfer_done && !nack_flag));

    assert_nack_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (inflight && bus_byte_done && !bus_ack) |=> (bus_stop && nack_flag));

    assert_stop_alone_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |-> (!bus_byte_valid && !tx_req));

    assert_hold_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_hold |-> (!busy && !bus_stop));
endmodule

bind smbus_pec_tx_seq smbus_pec_tx_seq_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_start      (bus_start),
    .bus_byte_valid (bus_byte_valid),
    .bus_byte_done  (bus_byte_done),
    .bus_ack        (bus_ack),
    .bus_stop       (bus_stop),
    .busy           (busy),
    .bus_hold       (bus_hold),
    .xfer_done      (xfer_done),
    .nack_flag      (nack_flag),
    .tx_req         (tx_req)
);

// File: tb/sim_smbus_pec_tx_seq.sv
// Directed bench: one task per scenario, with a byte engine and host modelled
// cycle by cycle inside run_xfer.
module sim_smbus_pec_tx_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_req = 1'b0;
    logic [7:0] addr_byte = '0;
    logic [7:0] byte_count = '0;
    logic       pec_en = 1'b0;
    logic       auto_end = 1'b0;
    logic       tx_req;
    logic       wr_strobe = 1'b0;
    logic [7:0] wr_data = '0;
    logic       bus_start;
    logic       bus_byte_valid;
    logic [7:0] bus_byte;
    logic       bus_byte_done = 1'b0;
    logic       bus_ack = 1'b1;
    logic       bus_stop;
    logic       busy;
    logic       bus_hold;
    logic       xfer_done;
    logic       nack_flag;

    int n_checks = 0;
    int n_fail = 0;

    logic [7:0] seen [0:31];
    int n_seen, n_req, n_start, n_stop, overlap;

    always #5 clk = ~clk;

    smbus_pec_tx_seq u0 (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .addr_byte(addr_byte),
        .byte_count(byte_count), .pec_en(pec_en), .auto_end(auto_end),
        .tx_req(tx_req), .wr_strobe(wr_strobe), .wr_data(wr_data),
        .bus_start(bus_start), .bus_byte_valid(bus_byte_valid), .bus_byte(bus_byte),
        .bus_byte_done(bus_byte_done), .bus_ack(bus_ack), .bus_stop(bus_stop),
        .busy(busy), .bus_hold(bus_hold), .xfer_done(xfer_done), .nack_flag(nack_flag)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] data_at(input logic [7:0] seed, input int k);
        return seed ^ 8'(k * 8'h3b + 8'h11);
    endfunction

    // Bitwise CRC-8, polynomial 0x07, MSB first.
    function automatic logic [7:0] crc_byte(input logic [7:0] c, input logic [7:0] b);
        logic [7:0] r = c ^ b;
        for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
        return r;
    endfunction

    function automatic logic [7:0] exp_pec(input logic [7:0] a, input logic [7:0] seed,
                                           input int nd);
        logic [7:0] c = crc_byte(8'h00, a);
        for (int i = 0; i < nd; i++) c = crc_byte(c, data_at(seed, i));
        return c;
    endfunction

    // Starts a transfer and plays engine and host until the block settles.
    task automatic run_xfer(input logic [7:0] a, input int n, input bit pec, input bit ae,
                            input logic [7:0] seed, input int nack_at, input bit poke);
        int dcnt = 0, scnt = 0, k = 0, quiet = 0, cyc = 0;
        bit seen_busy = 0;
        n_seen = 0; n_req = 0; n_start = 0; n_stop = 0; overlap = 0;
        @(negedge clk);
        addr_byte = a; byte_count = 8'(n); pec_en = pec; auto_end = ae;
        start_req = 1'b1;
        while (cyc < 400) begin
            @(negedge clk);
            cyc++;
            start_req = 1'b0; bus_byte_done = 1'b0; wr_strobe = 1'b0; bus_ack = 1'b1;
            byte_count = 8'(n); pec_en = pec;
            if (poke && cyc == 4) begin
                start_req = 1'b1; byte_count = 8'd9; pec_en = ~pec; addr_byte = 8'hff;
            end
            if (busy) seen_busy = 1;
            if (bus_byte_valid) begin
                if (dcnt > 0) overlap++;
                if (n_seen < 32) seen[n_seen] = bus_byte;
                n_seen++;
                dcnt = 2;
            end
            if (tx_req)    begin n_req++; scnt = 2; end
            if (bus_start) n_start++;
            if (bus_stop)  n_stop++;
            if (dcnt > 0) begin
                dcnt--;
                if (dcnt == 0) begin
                    bus_byte_done = 1'b1;
                    bus_ack = !(n_seen - 1 == nack_at);
                end
            end
            if (scnt > 0) begin
                scnt--;
                if (scnt == 0) begin
                    wr_strobe = 1'b1; wr_data = data_at(seed, k); k++;
                end
            end
            quiet = (seen_busy && !busy) ? quiet + 1 : 0;
            if (quiet >= 3) break;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!busy && !bus_hold && !xfer_done && !nack_flag, "R1 idle flags", busy, 0);
        chk(!tx_req && !bus_start && !bus_byte_valid && !bus_stop, "R1 strobes", tx_req, 0);
    endtask

    task automatic t_pec_autoend();
        run_xfer(8'h5a, 3, 1, 1, 8'h20, -1, 0);
        chk(n_req == 2, "R4 request count", n_req, 2);
        chk(n_seen == 4, "R4 byte count", n_seen, 4);
        chk(n_start == 1 && seen[0] == 8'h5a, "R3 address first", seen[0], 8'h5a);
        chk(seen[1] == data_at(8'h20, 0) && seen[2] == data_at(8'h20, 1), "R4 data order",
            seen[2], data_at(8'h20, 1));
        chk(seen[3] == exp_pec(8'h5a, 8'h20, 2), "R6 pec value", seen[3], exp_pec(8'h5a, 8'h20, 2));
        chk(n_stop == 1 && xfer_done && !bus_hold, "R7 stop and done", n_stop, 1);
        chk(overlap == 0, "R12 one byte in flight", overlap, 0);
    endtask

    task automatic t_no_pec();
        run_xfer(8'ha4, 3, 0, 1, 8'h71, -1, 0);
        chk(n_req == 3, "R5 request count", n_req, 3);
        chk(n_seen == 4, "R5 no extra byte", n_seen, 4);
        chk(seen[3] == data_at(8'h71, 2), "R5 last is host byte", seen[3], data_at(8'h71, 2));
    endtask

    task automatic t_short_counts();
        run_xfer(8'h3c, 1, 1, 1, 8'h00, -1, 0);
        chk(n_req == 0, "R11 no request for pec only", n_req, 0);
        chk(n_seen == 2 && seen[1] == exp_pec(8'h3c, 8'h00, 0), "R11 pec after address",
            seen[1], exp_pec(8'h3c, 8'h00, 0));
        run_xfer(8'h3d, 0, 1, 1, 8'h00, -1, 0);
        chk(n_seen == 1 && n_req == 0 && n_stop == 1, "R11 zero count", n_seen, 1);
    endtask

    task automatic t_hold_restart();
        run_xfer(8'h90, 2, 1, 0, 8'h44, -1, 0);
        chk(n_stop == 0, "R8 no stop", n_stop, 0);
        chk(bus_hold && xfer_done && !busy, "R8 hold and done", bus_hold, 1);
        chk(seen[2] == exp_pec(8'h90, 8'h44, 1), "R6 pec first frame", seen[2],
            exp_pec(8'h90, 8'h44, 1));
        run_xfer(8'h91, 3, 1, 1, 8'h0f, -1, 0);
        chk(n_start == 1 && seen[0] == 8'h91, "R8 repeated start", n_start, 1);
        chk(seen[3] == exp_pec(8'h91, 8'h0f, 2), "R9 pec restarts", seen[3],
            exp_pec(8'h91, 8'h0f, 2));
        chk(!bus_hold && n_stop == 1, "R7 stop after restart frame", n_stop, 1);
    endtask

    task automatic t_nack();
        run_xfer(8'h66, 4, 0, 1, 8'h33, 2, 0);
        chk(n_seen == 3, "R10 no byte after nack", n_seen, 3);
        chk(n_req == 2, "R10 no request after nack", n_req, 2);
        chk(nack_flag && !xfer_done && n_stop == 1, "R10 flag and stop", nack_flag, 1);
    endtask

    task automatic t_busy_start();
        run_xfer(8'h12, 3, 1, 1, 8'h5e, -1, 1);
        chk(n_start == 1 && n_seen == 4 && n_req == 2, "R2 start ignored while busy", n_seen, 4);
        chk(seen[0] == 8'h12 && seen[3] == exp_pec(8'h12, 8'h5e, 2), "R2 frame unchanged",
            seen[3], exp_pec(8'h12, 8'h5e, 2));
        chk(!nack_flag && xfer_done, "R2 clean finish", xfer_done, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_pec_autoend();
        t_no_pec();
        t_short_counts();
        t_hold_restart();
        t_nack();
        t_busy_start();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule